// File: doc/BRIEF.md
# Complementary Dual-Copy Hold Voter

This block combines the results of two identical redundant modules into one protected word, using two copies instead of the three that a majority vote needs. The first copy arrives in true polarity and the second arrives inverted. When no error is present, each bit of the inverted copy is the exact opposite of the matching bit of the true copy.

For every bit, a first stage turns the two copies into an active-low set request and an active-low clear request. The set path rests at logic 1 and pulls low only when the copies agree on a 1. The clear path rests at logic 1 and pulls low only when the copies agree on a 0. A second stage works like a clocked set/clear latch. A set request loads a 1 and a clear request loads a 0. When the copies disagree, no request is active and the stored bit keeps its last good value. This way a single corrupted copy never reaches the output.

The stored word is presented together with its complement, which is held in its own register. A following stage can therefore take the pair directly as its next true/inverted input pair without adding another voter. A per-bit flag marks the bits whose copies failed the complementary check.

Top module: `cdv_voter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge sets `q` to all zeros, `q_n` to all ones and `mismatch` to all zeros.
- R2: A bit with `din_t`=1 and `din_c`=0 at a rising edge (not in reset) reads 1 on `q` after that edge.
- R3: A bit with `din_t`=0 and `din_c`=1 at a rising edge (not in reset) reads 0 on `q` after that edge.
- R4: A bit with `din_t` equal to `din_c` (00 or 11) at a rising edge keeps the value `q` had before that edge.
- R5: After every rising edge, `q_n` is the bitwise inverse of `q`.
- R6: After every rising edge outside reset, `mismatch[i]` is 1 exactly when `din_t[i]` equalled `din_c[i]` at that edge.
- R7: Each bit is updated, held and flagged independently of all the other bits of the word.
- R8: A hold lasts through any number of consecutive disagreeing cycles, including the ones directly after reset, where the bit stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din_t | input | WIDTH | Redundant copy in true polarity |
| din_c | input | WIDTH | Redundant copy in inverted polarity |
| q | output | WIDTH | Protected value |
| q_n | output | WIDTH | Complement of the protected value |
| mismatch | output | WIDTH | Per-bit flag: the copies failed the complementary check |

## Verification
Each of the three outputs is registered once. A copy pair presented before a rising edge therefore shows up on `q`, `q_n` and `mismatch` right after that edge, and reset likewise acts one edge after `rst_n` is sampled low. The bench changes its inputs at the falling edge. After the next rising edge it updates a behavioural per-bit model from the inputs it drove. At the following falling edge it compares all three outputs with that model, so every comparison is made exactly one edge after its stimulus. The stimulus covers whole-word set and clear, both disagreement codes, mixed words and long holds, including holds that start directly after reset.

// File: rtl/cdv_pkg.sv
// Package: shared definitions for the complementary dual-copy voter.
// Assumes: a lane request is a pair of active-low strobes (set, clear).
package cdv_pkg;

    // Decoded meaning of one lane's request pair.
    typedef enum logic [1:0] {
        LANE_HOLD  = 2'b00,
        LANE_SET   = 2'b01,
        LANE_CLEAR = 2'b10,
        LANE_BAD   = 2'b11
    } lane_act_e;

    // Turns the active-low strobes into an action code.
    function automatic lane_act_e decode_req(input logic set_n, input logic clr_n);
        lane_act_e a;
        case ({clr_n, set_n})
            2'b10:   a = LANE_SET;
            2'b01:   a = LANE_CLEAR;
            2'b11:   a = LANE_HOLD;
            default: a = LANE_BAD;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/cdv_front.sv
// Module: first stage for one bit.
// The set path rests high and pulls low only when the copies agree on 1.
// The clear path rests high and pulls low only when the copies agree on 0.
// Assumes: bit_c carries the inverse of bit_t when there is no error.
module cdv_front (
    input  logic bit_t,
    input  logic bit_c,
    output logic set_n,
    output logic clr_n
);
    // NAND-style request generation for the two complementary paths.
    always_comb begin
        set_n = ~(bit_t & ~bit_c);
        clr_n = ~(~bit_t & bit_c);
    end
endmodule

// File: rtl/cdv_latch.sv
// Module: second stage for one bit, a clocked set/clear latch.
// It keeps the true value and the complement in separate registers.
// Assumes: synchronous active-low reset; the front never asserts both strobes.
module cdv_latch
    import cdv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_n,
    input  logic clr_n,
    output logic q,
    output logic q_b,
    output logic mis
);
    lane_act_e act;

    // Decode the request pair.
    always_comb act = decode_req(set_n, clr_n);

    // Update or hold the stored pair and record the disagreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            q_b <= 1'b1;
            mis <= 1'b0;
        end else begin
            mis <= (act == LANE_HOLD);
            if (act == LANE_SET) begin
                q   <= 1'b1;
                q_b <= 1'b0;
            end else if (act == LANE_CLEAR) begin
                q   <= 1'b0;
                q_b <= 1'b1;
            end
        end
    end

    // R2: a set request loads 1
    assert_set_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_n && clr_n) |=> q);
    // R3: a clear request loads 0
    assert_clear_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_n && !clr_n) |=> !q);
    // R4: no request keeps the stored value
    assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_n && clr_n) |=> $stable(q));
    // R6: the flag follows the disagreement
    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_n && clr_n) |=> mis);
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_n || !clr_n) |=> !mis);
endmodule

// File: rtl/cdv_voter.sv
// Module: top of the complementary dual-copy hold voter.
// It builds one front and one latch for every bit, so each bit works on its own.
// Assumes: din_c is the bitwise inverse of din_t when there is no error.
module cdv_voter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_t,
    input  logic [WIDTH-1:0] din_c,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_n,
    output logic [WIDTH-1:0] mismatch
);
    logic [WIDTH-1:0] set_n;
    logic [WIDTH-1:0] clr_n;

    // R7: one independent lane per bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        cdv_front u_front (
            .bit_t (din_t[i]),
            .bit_c (din_c[i]),
            .set_n (set_n[i]),
            .clr_n (clr_n[i])
        );
        cdv_latch u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .set_n (set_n[i]),
            .clr_n (clr_n[i]),
            .q     (q[i]),
            .q_b   (q_n[i]),
            .mis   (mismatch[i])
        );
    end

    // R5: the two output registers stay complementary
    assert_pair_inverse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_n == ~q));
    // R1: reset clears the state
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (q == '0) && (q_n == '1) && (mismatch == '0));
endmodule

// File: tb/cdv_voter_tb.sv
module cdv_voter_tb;
    localparam int WIDTH = 8;
    localparam time CLK_PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] din_t = '0;
    logic [WIDTH-1:0] din_c = '0;
    logic [WIDTH-1:0] q, q_n, mismatch;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit ref_q [WIDTH];
    bit ref_m [WIDTH];

    cdv_voter #(.WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .din_t(din_t), .din_c(din_c),
        .q(q), .q_n(q_n), .mismatch(mismatch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [WIDTH-1:0] pack(input bit a [WIDTH]);
        logic [WIDTH-1:0] v;
        for (int i = 0; i < WIDTH; i++) v[i] = a[i];
        return v;
    endfunction

    task automatic check(input string tag);
        logic [WIDTH-1:0] eq, em;
        eq = pack(ref_q);
        em = pack(ref_m);
        n_checks++;
        if (q !== eq || q_n !== ~eq || mismatch !== em) begin
            n_fail++;
            $display("FAIL %s: q=%h q_n=%h mismatch=%h expected q=%h q_n=%h mismatch=%h",
                     tag, q, q_n, mismatch, eq, ~eq, em);
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(input logic r, input logic [WIDTH-1:0] t,
                        input logic [WIDTH-1:0] c, input string tag);
        rst_n = r; din_t = t; din_c = c;
        @(posedge clk);
        for (int i = 0; i < WIDTH; i++) begin
            if (!r) begin
                ref_q[i] = 1'b0; ref_m[i] = 1'b0;
            end else begin
                ref_m[i] = (t[i] == c[i]);
                if (t[i] && !c[i]) ref_q[i] = 1'b1;
                else if (!t[i] && c[i]) ref_q[i] = 1'b0;
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        @(negedge clk);
        step(1'b0, 8'hFF, 8'h00, "R1 reset");
        step(1'b0, 8'h5A, 8'hA5, "R1 reset held");
        // R8: disagreement directly after reset keeps zeros
        step(1'b1, 8'hFF, 8'hFF, "R8 hold after reset");
        step(1'b1, 8'h00, 8'h00, "R8 hold after reset 00");
        step(1'b1, 8'hFF, 8'h00, "R2 set all");
        step(1'b1, 8'h00, 8'h00, "R4 hold 00");
        step(1'b1, 8'hFF, 8'hFF, "R4 hold 11");
        step(1'b1, 8'h00, 8'hFF, "R3 clear all");
        step(1'b1, 8'hFF, 8'hFF, "R6 flag all");
        // R7: mixed lanes, different actions per bit
        step(1'b1, 8'b1100_1010, 8'b0011_0110, "R7 mixed");
        step(1'b1, 8'b1010_0000, 8'b0101_1111, "R7 mixed 2");
        step(1'b1, 8'b0000_1111, 8'b1111_1111, "R7 partial hold");
        // R8: long hold
        step(1'b1, 8'h3C, 8'hC3, "R2 load pattern");
        for (int k = 0; k < 20; k++) begin
            logic [WIDTH-1:0] t;
            t = WIDTH'($urandom);
            step(1'b1, t, t, "R8 long hold");
        end
        // Random mix, including single-copy corruption
        for (int k = 0; k < 300; k++) begin
            logic [WIDTH-1:0] t, c;
            t = WIDTH'($urandom);
            c = ~t ^ WIDTH'($urandom & $urandom);
            step((k % 97) != 50, t, c, "R5 random mix");
        end
        step(1'b0, 8'hFF, 8'h00, "R1 reset again");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule